// File: doc/BRIEF.md
# Bulk Translation Entry Update Sequencer

This block takes one command and rewrites a run of consecutive I/O translation entries. In fill mode a single entry value goes to every page in the run. In list mode the values come from a list in memory: the block reads one 64-bit word at a time through a read-request/response master port, converts it from big-endian byte order, and writes it to the next page. Every write goes through the single-entry write port of the translation table. The table and the memory behind the list are outside this block.

A command is presented on plain control pins with a one-cycle `cmd_start` pulse. The command is checked before any work starts. A wrong table identifier, a count that is out of range or a misaligned list base ends the command at once with a parameter error. Otherwise the block walks the pages from the start address, rounded down to a page boundary. It stops at the first write the table refuses. When it finishes, `done` pulses and the status, the number of entries written and an index remain on the result pins until the next accepted command.

The read request, the read response and the table write each use a valid/ready handshake. A valid signal stays high and its payload stays stable until ready is seen high at a clock edge. The block raises `rd_rsp_ready` only while it is waiting for a list word. A slow `rd_req_ready`, `rd_rsp_valid` or `tw_ready` therefore stalls the walk without losing or repeating a step. The table returns its verdict on `tw_err_code` in the same cycle as the write handshake.

Top module: `xlate_bulk_update`

## Requirements
- R1: Write k of a command (k counted from 0) goes to `tw_addr` = (`cmd_bus_addr` with its low PAGE_SHIFT bits cleared) + k × 2^PAGE_SHIFT.
- R2: In fill mode (`cmd_list_mode`=0), every write carries `cmd_value` unchanged on `tw_entry`.
- R3: In fill mode, a `cmd_count` greater than TABLE_ENTRIES ends the command with status 1 (parameter error), count 0 and no write.
- R4: In list mode, a `cmd_count` greater than LIST_MAX (512) ends the command with status 1, count 0, and no read and no write.
- R5: In list mode, a list base (`cmd_value[ADDR_W-1:0]`) with any of bits [11:0] set ends the command with status 1, count 0, and no read and no write.
- R6: In list mode, read k goes to list base + 8k. The response byte in `rd_rsp_data[8j+7:8j]` is the byte at address offset j. That byte becomes `tw_entry[63-8j:56-8j]` of write k, so the word is read as big-endian.
- R7: When the table answers a write with a nonzero `tw_err_code`, no further read or write follows. The final status is that code, and the count equals the number of writes accepted before it.
- R8: A `cmd_table_id` different from TABLE_ID ends the command with status 1, count 0 and no bus activity.
- R9: A valid command with `cmd_count` = 0 ends with status 0 and count 0, without any read or write. Every command ends with `done` high for exactly one cycle.
- R10: A `cmd_start` pulse while `busy` is high is ignored.
- R11: After `done`, `done_index` is `done_count`−1, or 0 when `done_count` is 0.
- R12: `rd_req_valid` and `tw_valid`, with their payloads, are held steady until the matching ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle command request, taken only when not busy |
| cmd_list_mode | input | 1 | 0 = fill mode, 1 = list mode |
| cmd_table_id | input | 32 | Table identifier, compared with TABLE_ID |
| cmd_bus_addr | input | ADDR_W | Start bus address, rounded down to a page |
| cmd_value | input | 64 | Fill-mode entry value, or list base address in the low ADDR_W bits |
| cmd_count | input | CNT_W | Number of entries to write |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 = success, 1 = parameter error, otherwise the table's error code |
| done_count | output | CNT_W | Entries written successfully |
| done_index | output | CNT_W | Last successful entry, or 0 when none was written |
| rd_req_valid | output | 1 | List read request valid |
| rd_req_ready | input | 1 | List read request accepted |
| rd_req_addr | output | ADDR_W | Byte address of the list word |
| rd_rsp_valid | input | 1 | List read data valid |
| rd_rsp_ready | output | 1 | Block is waiting for list data |
| rd_rsp_data | input | 64 | List word, byte j in bits [8j+7:8j] |
| tw_valid | output | 1 | Table write valid |
| tw_ready | input | 1 | Table write accepted |
| tw_addr | output | ADDR_W | Page-aligned bus address of the entry |
| tw_entry | output | 64 | Entry value to store |
| tw_err_code | input | 2 | Table verdict during the write handshake, 0 = success |

## Verification
The bench uses a start address that is not page-aligned. A block that skipped the rounding down would write every page at an offset. List words are built so that each byte is different. A design that dropped the byte swap, or stepped the list pointer by one page instead of 8 bytes, would produce mismatching entries in the scoreboard.

The exact limits are exercised: a fill of TABLE_ENTRIES pages, a list of 512 words, one count above each limit, a misaligned list base, a wrong identifier and a count of zero. An off-by-one limit would either reject a legal command or let an illegal one write. Write errors are injected at the first entry and in the middle of a run. A block that kept going, or that counted the failed write, would show extra writes or a wrong count and index. A second start pulse is sent while a command is running. A block that accepted it would produce writes the scoreboard does not expect.

// File: rtl/xbu_pkg.sv
package xbu_pkg;
  localparam logic [1:0] ST_OK    = 2'd0;
  localparam logic [1:0] ST_PARAM = 2'd1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_RSP,
    S_WRITE,
    S_DONE
  } xbu_state_t;
endpackage

// File: rtl/xbu_cmd_check.sv
module xbu_cmd_check #(
  parameter int          ADDR_W           = 32,
  parameter int          CNT_W            = 16,
  parameter int          TABLE_ENTRIES    = 256,
  parameter int          LIST_MAX         = 512,
  parameter int          LIST_ALIGN_SHIFT = 12,
  parameter logic [31:0] TABLE_ID         = 32'h0000_0042
) (
  input  logic              list_mode,
  input  logic [31:0]       table_id,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] list_base,
  output logic              cmd_ok
);
  localparam logic [CNT_W:0] FILL_LIM = (CNT_W+1)'(TABLE_ENTRIES);
  localparam logic [CNT_W:0] LIST_LIM = (CNT_W+1)'(LIST_MAX);

  logic id_ok, fill_ok, list_ok;

  always_comb begin
    id_ok   = (table_id == TABLE_ID);
    fill_ok = ({1'b0, count} <= FILL_LIM);
    list_ok = ({1'b0, count} <= LIST_LIM) &&
              (list_base[LIST_ALIGN_SHIFT-1:0] == '0);
    cmd_ok  = id_ok && (list_mode ? list_ok : fill_ok);
  end
endmodule

// File: rtl/xbu_page_walker.sv
module xbu_page_walker #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int STRIDE     = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] start_page,
  input  logic [ADDR_W-3:0]        list_word,
  input  logic                     step_page,
  input  logic                     step_list,
  output logic [ADDR_W-1:0]        page_addr,
  output logic [ADDR_W-1:0]        list_addr
);
  localparam logic [ADDR_W-1:0] PAGE_BYTES = ADDR_W'(1) << PAGE_SHIFT;
  localparam logic [ADDR_W-1:0] LIST_STEP  = ADDR_W'(STRIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_addr <= '0;
      list_addr <= '0;
    end else if (load) begin
      page_addr <= {start_page, {PAGE_SHIFT{1'b0}}};
      list_addr <= {list_word, 2'b00};
    end else begin
      if (step_page) page_addr <= page_addr + PAGE_BYTES;
      if (step_list) list_addr <= list_addr + LIST_STEP;
    end
  end
endmodule

// File: rtl/xbu_be_swap.sv
module xbu_be_swap #(
  parameter int ENTRY_W = 64
) (
  input  logic [ENTRY_W-1:0] din,
  output logic [ENTRY_W-1:0] dout
);
  localparam int NBYTES = ENTRY_W / 8;

  for (genvar j = 0; j < NBYTES; j++) begin : g_byte
    assign dout[8*(NBYTES-1-j) +: 8] = din[8*j +: 8];
  end
endmodule

// File: rtl/xlate_bulk_update.sv
module xlate_bulk_update
  import xbu_pkg::*;
#(
  parameter int          ADDR_W           = 32,
  parameter int          ENTRY_W          = 64,
  parameter int          CNT_W            = 16,
  parameter int          PAGE_SHIFT       = 12,
  parameter int          TABLE_ENTRIES    = 256,
  parameter int          LIST_MAX         = 512,
  parameter int          LIST_ALIGN_SHIFT = 12,
  parameter logic [31:0] TABLE_ID         = 32'h0000_0042
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_start,
  input  logic               cmd_list_mode,
  input  logic [31:0]        cmd_table_id,
  input  logic [ADDR_W-1:0]  cmd_bus_addr,
  input  logic [ENTRY_W-1:0] cmd_value,
  input  logic [CNT_W-1:0]   cmd_count,
  output logic               busy,
  output logic               done,
  output logic [1:0]         status,
  output logic [CNT_W-1:0]   done_count,
  output logic [CNT_W-1:0]   done_index,
  output logic               rd_req_valid,
  input  logic               rd_req_ready,
  output logic [ADDR_W-1:0]  rd_req_addr,
  input  logic               rd_rsp_valid,
  output logic               rd_rsp_ready,
  input  logic [ENTRY_W-1:0] rd_rsp_data,
  output logic               tw_valid,
  input  logic               tw_ready,
  output logic [ADDR_W-1:0]  tw_addr,
  output logic [ENTRY_W-1:0] tw_entry,
  input  logic [1:0]         tw_err_code
);
  localparam int STRIDE = ENTRY_W / 8;

  xbu_state_t         st;
  logic               mode_q;
  logic [CNT_W-1:0]   total_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ENTRY_W-1:0] entry_q;
  logic [1:0]         status_q;
  logic               cmd_ok;
  logic [ENTRY_W-1:0] swapped;
  logic               accept, wr_fire, wr_good, last_good;

  xbu_cmd_check #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .TABLE_ENTRIES(TABLE_ENTRIES),
    .LIST_MAX(LIST_MAX), .LIST_ALIGN_SHIFT(LIST_ALIGN_SHIFT), .TABLE_ID(TABLE_ID)
  ) i_check (
    .list_mode (cmd_list_mode),
    .table_id  (cmd_table_id),
    .count     (cmd_count),
    .list_base (cmd_value[ADDR_W-1:0]),
    .cmd_ok    (cmd_ok)
  );

  xbu_page_walker #(
    .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .STRIDE(STRIDE)
  ) i_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .start_page (cmd_bus_addr[ADDR_W-1:PAGE_SHIFT]),
    .list_word  (cmd_value[ADDR_W-1:2]),
    .step_page  (wr_good),
    .step_list  (st == S_RSP && rd_rsp_valid),
    .page_addr  (tw_addr),
    .list_addr  (rd_req_addr)
  );

  xbu_be_swap #(.ENTRY_W(ENTRY_W)) i_swap (
    .din  (rd_rsp_data),
    .dout (swapped)
  );

  always_comb begin
    accept    = (st == S_IDLE) && cmd_start;
    wr_fire   = (st == S_WRITE) && tw_ready;
    wr_good   = wr_fire && (tw_err_code == 2'd0);
    last_good = ((cnt_q + 1'b1) == total_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= 1'b0;
      total_q  <= '0;
      cnt_q    <= '0;
      entry_q  <= '0;
      status_q <= ST_OK;
    end else begin
      case (st)
        S_IDLE: if (cmd_start) begin
          mode_q  <= cmd_list_mode;
          total_q <= cmd_count;
          cnt_q   <= '0;
          entry_q <= cmd_value;
          if (!cmd_ok) begin
            status_q <= ST_PARAM;
            st       <= S_DONE;
          end else if (cmd_count == '0) begin
            status_q <= ST_OK;
            st       <= S_DONE;
          end else begin
            st <= cmd_list_mode ? S_REQ : S_WRITE;
          end
        end
        S_REQ: if (rd_req_ready) st <= S_RSP;
        S_RSP: if (rd_rsp_valid) begin
          entry_q <= swapped;
          st      <= S_WRITE;
        end
        S_WRITE: if (tw_ready) begin
          if (tw_err_code != 2'd0) begin
            status_q <= tw_err_code;
            st       <= S_DONE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (last_good) begin
              status_q <= ST_OK;
              st       <= S_DONE;
            end else begin
              st <= mode_q ? S_REQ : S_WRITE;
            end
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy         = (st != S_IDLE);
    done         = (st == S_DONE);
    status       = status_q;
    done_count   = cnt_q;
    done_index   = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    rd_req_valid = (st == S_REQ);
    rd_rsp_ready = (st == S_RSP);
    tw_valid     = (st == S_WRITE);
    tw_entry     = entry_q;
  end
endmodule

// File: rtl/xbu_checker.sv
module xbu_checker #(
  parameter int ADDR_W     = 32,
  parameter int ENTRY_W    = 64,
  parameter int CNT_W      = 16,
  parameter int PAGE_SHIFT = 12
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               done,
  input logic [1:0]         status,
  input logic [CNT_W-1:0]   done_count,
  input logic [CNT_W-1:0]   done_index,
  input logic               rd_req_valid,
  input logic               rd_req_ready,
  input logic [ADDR_W-1:0]  rd_req_addr,
  input logic               tw_valid,
  input logic               tw_ready,
  input logic [ADDR_W-1:0]  tw_addr,
  input logic [ENTRY_W-1:0] tw_entry
);
  assert_page_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tw_valid |-> tw_addr[PAGE_SHIFT-1:0] == '0);

  assert_list_word_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> rd_req_addr[2:0] == 3'd0);

  assert_one_port_at_a_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tw_valid |-> !rd_req_valid);

  assert_param_no_work_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'd1) |-> done_count == '0);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_empty_index_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_count == '0) |-> done_index == '0);

  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  assert_tw_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tw_valid && !tw_ready) |=> (tw_valid && $stable(tw_addr) && $stable(tw_entry)));
endmodule

bind xlate_bulk_update xbu_checker #(
  .ADDR_W(ADDR_W), .ENTRY_W(ENTRY_W), .CNT_W(CNT_W), .PAGE_SHIFT(PAGE_SHIFT)
) i_xbu_checker (.*);

// File: tb/test_xlate_bulk_update.sv
module test_xlate_bulk_update;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int TABLE_ENTRIES = 256;
  localparam logic [31:0] TID = 32'h0000_0042;

  logic clk, rst_n;
  logic cmd_start, cmd_list_mode;
  logic [31:0] cmd_table_id;
  logic [ADDR_W-1:0] cmd_bus_addr;
  logic [63:0] cmd_value;
  logic [CNT_W-1:0] cmd_count;
  logic busy, done;
  logic [1:0] status;
  logic [CNT_W-1:0] done_count, done_index;
  logic rd_req_valid, rd_req_ready, rd_rsp_valid, rd_rsp_ready;
  logic [ADDR_W-1:0] rd_req_addr;
  logic [63:0] rd_rsp_data;
  logic tw_valid, tw_ready;
  logic [ADDR_W-1:0] tw_addr;
  logic [63:0] tw_entry;
  logic [1:0] tw_err_code;

  xlate_bulk_update i_xlate_bulk_update (.*);

  int errors = 0, checks = 0;
  string tag = "reset";
  logic [ADDR_W-1:0] exp_wa[$];
  logic [63:0] exp_we[$];
  logic [ADDR_W-1:0] exp_ra[$];
  bit err_en = 0;
  logic [ADDR_W-1:0] err_addr = '0;
  logic [1:0] err_code = 2'd0;
  int tcyc = 0, mcyc = 0, wd = 0;
  bit pend = 0, rsp_taken = 0;
  logic [ADDR_W-1:0] pend_addr;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] membyte(logic [ADDR_W-1:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [63:0] raw_word(logic [ADDR_W-1:0] a);
    logic [63:0] w;
    for (int j = 0; j < 8; j++) w[8*j +: 8] = membyte(a + ADDR_W'(j));
    return w;
  endfunction

  function automatic logic [63:0] be_word(logic [ADDR_W-1:0] a);
    logic [63:0] w;
    for (int j = 0; j < 8; j++) w[8*(7-j) +: 8] = membyte(a + ADDR_W'(j));
    return w;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // table model and write scoreboard monitor
  always @(negedge clk) begin
    tcyc++;
    tw_ready = ((tcyc % 3) != 1);
    tw_err_code = (err_en && tw_addr == err_addr) ? err_code : 2'd0;
    if (tw_valid && tw_ready) begin
      if (exp_wa.size() == 0) check(0, tag, "unexpected write", 64'(tw_addr), 0);
      else begin
        logic [ADDR_W-1:0] ea;
        logic [63:0] ee;
        ea = exp_wa.pop_front();
        ee = exp_we.pop_front();
        check(tw_addr == ea, tag, "write addr", 64'(tw_addr), 64'(ea));
        check(tw_entry == ee, tag, "write entry", tw_entry, ee);
      end
    end
  end

  // list memory model and read-address monitor
  always @(negedge clk) begin
    mcyc++;
    if (rsp_taken) begin rd_rsp_valid = 1'b0; rsp_taken = 0; end
    if (!rd_rsp_valid && pend && (mcyc % 2 == 1)) begin
      rd_rsp_valid = 1'b1;
      rd_rsp_data = raw_word(pend_addr);
      pend = 0;
    end
    if (rd_rsp_valid && rd_rsp_ready) rsp_taken = 1;
    rd_req_ready = ((mcyc % 4) != 0);
    if (rd_req_valid && rd_req_ready) begin
      if (exp_ra.size() == 0) check(0, tag, "unexpected read", 64'(rd_req_addr), 0);
      else begin
        logic [ADDR_W-1:0] ra;
        ra = exp_ra.pop_front();
        check(rd_req_addr == ra, tag, "read addr", 64'(rd_req_addr), 64'(ra));
      end
      pend = 1;
      pend_addr = rd_req_addr;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  // driver: pushes expected items, issues command, checks results
  task automatic run_cmd(bit lm, logic [31:0] id, logic [ADDR_W-1:0] ba, logic [63:0] val,
                         int cnt, int nwr, logic [1:0] est, int ecnt, string t, bit intrude);
    logic [ADDR_W-1:0] al;
    int w;
    logic [CNT_W-1:0] eidx;
    tag = t;
    al = {ba[ADDR_W-1:12], 12'h000};
    for (int k = 0; k < nwr; k++) begin
      exp_wa.push_back(al + ADDR_W'(k) * ADDR_W'(4096));
      if (lm) begin
        exp_we.push_back(be_word(val[ADDR_W-1:0] + ADDR_W'(8*k)));
        exp_ra.push_back(val[ADDR_W-1:0] + ADDR_W'(8*k));
      end else exp_we.push_back(val);
    end
    @(negedge clk);
    cmd_list_mode = lm; cmd_table_id = id; cmd_bus_addr = ba;
    cmd_value = val; cmd_count = CNT_W'(cnt); cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    if (intrude) begin
      repeat (3) @(negedge clk);
      check(busy, "R10", "busy before second start", 64'(busy), 1);
      cmd_list_mode = 1'b0; cmd_table_id = TID; cmd_bus_addr = 32'h0009_0000;
      cmd_value = 64'hDEAD_BEEF; cmd_count = 3; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
    end
    w = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    check(done, t, "done seen", 64'(done), 1);
    eidx = (ecnt == 0) ? '0 : CNT_W'(ecnt - 1);
    check(status == est, t, "status", 64'(status), 64'(est));
    check(done_count == CNT_W'(ecnt), t, "done_count", 64'(done_count), 64'(ecnt));
    check(done_index == eidx, "R11", {t, " done_index"}, 64'(done_index), 64'(eidx));
    check(exp_wa.size() == 0, t, "writes missing", 64'(exp_wa.size()), 0);
    check(exp_ra.size() == 0, t, "reads missing", 64'(exp_ra.size()), 0);
    @(negedge clk);
    check(!done, "R9", {t, " done one cycle"}, 64'(done), 0);
    exp_wa.delete(); exp_we.delete(); exp_ra.delete();
  endtask

  initial begin
    rst_n = 1'b0; cmd_start = 1'b0; cmd_list_mode = 1'b0; cmd_table_id = '0;
    cmd_bus_addr = '0; cmd_value = '0; cmd_count = '0;
    rd_req_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    tw_ready = 1'b0; tw_err_code = 2'd0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !tw_valid && !rd_req_valid, "R10", "reset idle",
          {busy, done, tw_valid, rd_req_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_cmd(0, TID, 32'h0012_3456, 64'h0123_4567_89AB_CDE3, 5, 5, 2'd0, 5, "R1 R2 fill unaligned start", 0);
    run_cmd(1, TID, 32'h0040_0FFF, 64'h0001_0000, 4, 4, 2'd0, 4, "R6 list fetch", 0);
    run_cmd(0, TID, 32'h0000_0000, 64'h55, 0, 0, 2'd0, 0, "R9 zero count", 0);
    run_cmd(0, TID, 32'h0000_0000, 64'h77, TABLE_ENTRIES, TABLE_ENTRIES, 2'd0, TABLE_ENTRIES, "R3 fill at limit", 0);
    run_cmd(0, TID, 32'h0000_0000, 64'h77, TABLE_ENTRIES + 1, 0, 2'd1, 0, "R3 fill over limit", 0);
    run_cmd(1, TID, 32'h0100_0000, 64'h0002_0000, 512, 512, 2'd0, 512, "R4 list at limit", 0);
    run_cmd(1, TID, 32'h0100_0000, 64'h0002_0000, 513, 0, 2'd1, 0, "R4 list over limit", 0);
    run_cmd(1, TID, 32'h0100_0000, 64'h0002_0008, 2, 0, 2'd1, 0, "R5 misaligned list", 0);
    run_cmd(0, 32'h0000_0043, 32'h0100_0000, 64'h11, 2, 0, 2'd1, 0, "R8 wrong table id", 0);

    err_en = 1; err_addr = 32'h0010_2000; err_code = 2'd2;
    run_cmd(0, TID, 32'h0010_0000, 64'hABCD, 6, 3, 2'd2, 2, "R7 error mid run", 0);
    err_addr = 32'h0020_0000; err_code = 2'd3;
    run_cmd(1, TID, 32'h0020_0000, 64'h0003_0000, 4, 1, 2'd3, 0, "R7 error first entry", 0);
    err_en = 0;

    run_cmd(1, TID, 32'h0030_0000, 64'h0004_0000, 6, 6, 2'd0, 6, "R10 start while busy", 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule